// File: doc/BRIEF.md
# Multi-format SPI master

This block is an SPI master that drives one serial word at a time onto SCLK and MOSI while capturing MISO. It holds four format register sets. Each set has its own clock divisor and character length. No single divisor or length applies to every transfer. Every word written to the data register carries a two-bit format select, and that select decides which set governs the transfer. The same word also carries a chip-select index, which picks the one active-low chip-select line that is driven during the transfer.

Software uses a flat write/read register port. Addresses 0 to 3 hold the format sets. Address 4 is the transmit/command register. Address 5 is status. Address 6 holds the last received word.

A write to address 4 while the block is idle starts a transfer. The chosen format values are latched at that moment, so later register writes cannot disturb the word in progress.

The engine is a four-state machine:
- **IDLE**: no transfer. IDLE goes to **LEAD** on an accepted start.
- **LEAD**: the chip select is asserted and SCLK stays low for one divided period. LEAD goes to **SHIFT** when that period ends.
- **SHIFT**: one divided period per bit. SHIFT goes to **TRAIL** at the end of the period of the last bit.
- **TRAIL**: SCLK is low and the chip select is still held for one more period. TRAIL returns to **IDLE** when that period ends. The done flag is set and the chip select is released on that return.

Top module: `spi_fmt_master`

## Requirements
- R1: After reset, all four format registers read 0 and status reads 0. SCLK is low and every cs_n line is high.
- R2: A format register stores a prescale value in bits 15:8 and a length field in bits 4:0. All other bits read back as 0.
- R3: During a transfer the SCLK period is D = PRESCALE+1 module clocks. SCLK is high for floor(D/2) clocks of each period and low otherwise. SCLK idles low.
- R4: Bits 25:24 of the data-register write select format set 0 to 3, and a value of 0 selects set 0. A change of the select field alone changes the SCLK period.
- R5: If the selected PRESCALE is 0 or 1, the transfer runs with D = 3 and the sticky status bit 1 is set. Writing address 5 with bit 1 set clears status bit 1.
- R6: The number of SCLK pulses equals the selected length field for values 1 to 16; a value of 0x10 gives 16. A field of 0 or above 16 gives 16 pulses.
- R7: Data goes out MSB first, taken from the low `length` bits of data-register bits 15:0. MOSI changes only while SCLK is low. MISO is sampled on each rising SCLK edge. The received word reads back right-aligned at address 6.
- R8: Only the cs_n line indexed by data-register bits 17:16 goes low. The first rising SCLK edge comes D+ceil(D/2) clocks after that line falls. The line rises D clocks after the last falling SCLK edge.
- R9: Format-register writes and data-register writes made during a transfer have no effect on it. A data write made while busy starts no transfer.
- R10: Status bit 0 (done) is set when cs_n is released and is cleared when the next transfer is accepted. Status bit 2 reads 1 while a transfer is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0-3 formats, 4 data, 5 status |
| wr_data | input | 26 | Write data |
| rd_addr | input | 3 | Read address: 0-3 formats, 5 status, 6 received word |
| rd_data | output | 26 | Combinational read data |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
A bad latched divisor or low-phase count shows up at the first SCLK pulse, as a wrong lead time, high time or period. The period check then catches it within two pulses. A wrong bit counter shows up at chip-select release, as a wrong pulse count or a truncated word. A wrong shift direction or sample point corrupts the MOSI and MISO words seen at the end of the same transfer. A lost latch shows up as a period change in the middle of the word when the format set is rewritten during the transfer.

// File: rtl/spi_fmt_pkg.sv
package spi_fmt_pkg;

    // format register fields
    localparam int PRE_LSB = 8;
    localparam int LEN_LSB = 0;

    // data register control fields
    localparam int CS_LSB  = 16;
    localparam int SEL_LSB = 24;

    // register map
    localparam int ADDR_W    = 3;
    localparam int ADDR_DATA = 4;
    localparam int ADDR_STAT = 5;
    localparam int ADDR_RX   = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL
    } eng_state_t;

endpackage

// File: rtl/spi_fmt_regs.sv
module spi_fmt_regs
    import spi_fmt_pkg::*;
#(
    parameter int NFMT  = 4,
    parameter int PRE_W = 8,
    parameter int LEN_W = 5,
    parameter int REG_W = 26,
    parameter int SEL_W = $clog2(NFMT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PRE_W-1:0]  wr_pre,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [SEL_W-1:0]  pick,
    output logic [PRE_W-1:0]  pick_pre,
    output logic [LEN_W-1:0]  pick_len,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_fmt
);

    logic [PRE_W-1:0] pre_q [NFMT];
    logic [LEN_W-1:0] len_q [NFMT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NFMT; i++) begin
                pre_q[i] <= '0;
                len_q[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < NFMT; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    pre_q[i] <= wr_pre;
                    len_q[i] <= wr_len;
                end
            end
        end
    end

    assign pick_pre = pre_q[pick];
    assign pick_len = len_q[pick];

    always_comb begin
        rd_fmt = '0;
        for (int i = 0; i < NFMT; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                rd_fmt = (REG_W'(pre_q[i]) << PRE_LSB) | (REG_W'(len_q[i]) << LEN_LSB);
            end
        end
    end

endmodule

// File: rtl/spi_fmt_engine.sv
module spi_fmt_engine
    import spi_fmt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PRE_W  = 8,
    parameter int LEN_W  = 5,
    parameter int NCS    = 4,
    parameter int CSI_W  = $clog2(NCS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] start_data,
    input  logic [CSI_W-1:0]  start_cs,
    input  logic [PRE_W-1:0]  sel_pre,
    input  logic [LEN_W-1:0]  sel_len,
    input  logic              clr_illegal,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic [NCS-1:0]    cs_n,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic [DATA_W-1:0] rx_word
);

    localparam int CNT_W = PRE_W + 1;
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(DATA_W);

    eng_state_t state_q, state_d;

    logic [CNT_W-1:0]  cnt_q, div_q, low_q;
    logic [LEN_W-1:0]  len_q, bit_q;
    logic [CSI_W-1:0]  cs_q;
    logic [DATA_W-1:0] sh_q, rx_q, rxw_q;
    logic              done_q, ill_q;

    logic              bad_pre;
    logic [PRE_W-1:0]  pre_eff;
    logic [CNT_W-1:0]  new_div;
    logic [LEN_W-1:0]  len_eff;
    logic              period_end, mid_point, last_bit, accept;

    always_comb begin
        bad_pre    = sel_pre < PRE_W'(2);
        pre_eff    = bad_pre ? PRE_W'(2) : sel_pre;
        new_div    = {1'b0, pre_eff} + CNT_W'(1);
        len_eff    = (sel_len == '0 || sel_len > FULL_LEN) ? FULL_LEN : sel_len;
        period_end = cnt_q == div_q - CNT_W'(1);
        mid_point  = cnt_q == low_q - CNT_W'(1);
        last_bit   = bit_q == len_q - LEN_W'(1);
        accept     = (state_q == ST_IDLE) && start;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)                   state_d = ST_LEAD;
            ST_LEAD:  if (period_end)              state_d = ST_SHIFT;
            ST_SHIFT: if (period_end && last_bit)  state_d = ST_TRAIL;
            ST_TRAIL: if (period_end)              state_d = ST_IDLE;
            default:                               state_d = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            div_q  <= CNT_W'(3);
            low_q  <= CNT_W'(2);
            len_q  <= FULL_LEN;
            bit_q  <= '0;
            cs_q   <= '0;
            sh_q   <= '0;
            rx_q   <= '0;
            rxw_q  <= '0;
            done_q <= 1'b0;
            ill_q  <= 1'b0;
        end else begin
            ill_q <= (ill_q & ~clr_illegal) | (accept & bad_pre);
            if (state_q == ST_IDLE) cnt_q <= '0;
            else                    cnt_q <= period_end ? '0 : cnt_q + CNT_W'(1);
            if (accept) begin
                div_q  <= new_div;
                low_q  <= new_div - (new_div >> 1);
                len_q  <= len_eff;
                cs_q   <= start_cs;
                sh_q   <= start_data << (FULL_LEN - len_eff);
                rx_q   <= '0;
                bit_q  <= '0;
                done_q <= 1'b0;
            end
            if (state_q == ST_SHIFT) begin
                if (mid_point) rx_q <= {rx_q[DATA_W-2:0], miso};
                if (period_end && !last_bit) begin
                    bit_q <= bit_q + LEN_W'(1);
                    sh_q  <= sh_q << 1;
                end
            end
            if (state_q == ST_TRAIL && period_end) begin
                done_q <= 1'b1;
                rxw_q  <= rx_q;
            end
        end
    end

    // outputs
    always_comb begin
        busy    = state_q != ST_IDLE;
        sclk    = (state_q == ST_SHIFT) && (cnt_q >= low_q);
        mosi    = busy ? sh_q[DATA_W-1] : 1'b0;
        cs_n    = busy ? ~(NCS'(1) << cs_q) : '1;
        done    = done_q;
        illegal = ill_q;
        rx_word = rxw_q;
    end

    // R8
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R3
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> !sclk);

    // R7
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R9
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(div_q) && $stable(len_q) && $stable(cs_q)));

    // R5
    div_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (div_q >= CNT_W'(3)));

    // R10
    done_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

endmodule

// File: rtl/spi_fmt_master.sv
module spi_fmt_master
    import spi_fmt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PRE_W  = 8,
    parameter int NFMT   = 4,
    parameter int NCS    = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [25:0] wr_data,
    input  logic [2:0]  rd_addr,
    output logic [25:0] rd_data,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic [NCS-1:0] cs_n
);

    localparam int REG_W = 26;
    localparam int SEL_W = $clog2(NFMT);
    localparam int CSI_W = $clog2(NCS);
    localparam int LEN_W = $clog2(DATA_W) + 1;

    logic [PRE_W-1:0]  pick_pre;
    logic [LEN_W-1:0]  pick_len;
    logic [REG_W-1:0]  rd_fmt;
    logic              busy, done, illegal, start, clr_ill;
    logic [DATA_W-1:0] rx_word;

    assign start   = wr_en && (wr_addr == ADDR_W'(ADDR_DATA)) && !busy;
    assign clr_ill = wr_en && (wr_addr == ADDR_W'(ADDR_STAT)) && wr_data[1];

    spi_fmt_regs #(
        .NFMT(NFMT), .PRE_W(PRE_W), .LEN_W(LEN_W), .REG_W(REG_W), .SEL_W(SEL_W)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_pre   (wr_data[PRE_LSB +: PRE_W]),
        .wr_len   (wr_data[LEN_LSB +: LEN_W]),
        .pick     (wr_data[SEL_LSB +: SEL_W]),
        .pick_pre (pick_pre),
        .pick_len (pick_len),
        .rd_addr  (rd_addr),
        .rd_fmt   (rd_fmt)
    );

    spi_fmt_engine #(
        .DATA_W(DATA_W), .PRE_W(PRE_W), .LEN_W(LEN_W), .NCS(NCS), .CSI_W(CSI_W)
    ) i_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_data  (wr_data[DATA_W-1:0]),
        .start_cs    (wr_data[CS_LSB +: CSI_W]),
        .sel_pre     (pick_pre),
        .sel_len     (pick_len),
        .clr_illegal (clr_ill),
        .miso        (miso),
        .sclk        (sclk),
        .mosi        (mosi),
        .cs_n        (cs_n),
        .busy        (busy),
        .done        (done),
        .illegal     (illegal),
        .rx_word     (rx_word)
    );

    always_comb begin
        unique case (rd_addr)
            ADDR_W'(ADDR_STAT): rd_data = {{(REG_W-3){1'b0}}, busy, illegal, done};
            ADDR_W'(ADDR_RX):   rd_data = REG_W'(rx_word);
            default:            rd_data = rd_fmt;
        endcase
    end

endmodule

// File: tb/test_spi_fmt_master.sv
`timescale 1ns/1ps
module test_spi_fmt_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [25:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [25:0] rd_data;
    logic        sclk, mosi, miso;
    logic [3:0]  cs_n;

    always #2 clk = ~clk;

    spi_fmt_master i_spi_fmt_master (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sclk(sclk), .mosi(mosi), .miso(miso),
        .cs_n(cs_n)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // slave model and edge monitor
    wire        cs_all = &cs_n;
    logic [15:0] slave_word = '0;
    int          slen = 16;
    int          k = 0;
    int          npulse = 0;
    logic [15:0] mosi_cap = '0;
    logic [3:0]  cs_seen = '1;
    time t_csf = 0, t_csr = 0, t_first = 0, t_last = 0, t_fall = 0, t_hi = 0;
    time pmin = 0, pmax = 0;

    assign miso = (k < slen) ? slave_word[slen-1-k] : 1'b0;

    always @(negedge cs_all) begin
        t_csf = $time; npulse = 0; mosi_cap = '0; k = 0; pmin = 0; pmax = 0;
    end
    always @(posedge cs_all) t_csr = $time;
    always @(posedge sclk) begin
        if (npulse == 0) begin
            t_first = $time; cs_seen = cs_n;
        end else begin
            if (pmin == 0 || ($time - t_last) < pmin) pmin = $time - t_last;
            if (($time - t_last) > pmax) pmax = $time - t_last;
        end
        t_last = $time;
        mosi_cap = {mosi_cap[14:0], mosi};
        npulse++;
    end
    always @(negedge sclk) begin
        if (npulse == 1) t_hi = $time - t_first;
        t_fall = $time;
        k++;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL R10 watchdog expired act=%0d exp=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tg, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tg, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [25:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [25:0] d);
        @(negedge clk);
        rd_addr = 3'(a);
        #0.5;
        d = rd_data;
    endtask

    function automatic logic [25:0] fmtv(input int p, input int l);
        return 26'((p << 8) | l);
    endfunction

    task automatic start_xfer(input int sel, input int csi, input logic [15:0] d,
                              input logic [15:0] sw, input int len);
        slave_word = sw; slen = len;
        wr(4, 26'((sel << 24) | (csi << 16)) | 26'(d));
    endtask

    task automatic wait_check(input int csi, input logic [15:0] d, input logic [15:0] sw,
                              input int dv, input int len, input string tg);
        logic [25:0]  v;
        logic [15:0]  mask;
        mask = (len == 16) ? 16'hFFFF : 16'((1 << len) - 1);
        @(posedge cs_all);
        @(negedge clk);
        chk({tg, " R6 pulse count"}, 32'(npulse), 32'(len));
        if (len > 1) begin
            chk({tg, " R3 period min"}, 32'(pmin / 4), 32'(dv));
            chk({tg, " R3 period max"}, 32'(pmax / 4), 32'(dv));
        end
        chk({tg, " R3 high time"}, 32'(t_hi / 4), 32'(dv / 2));
        chk({tg, " R8 lead"}, 32'((t_first - t_csf) / 4), 32'(dv + (dv - dv / 2)));
        chk({tg, " R8 tail"}, 32'((t_csr - t_fall) / 4), 32'(dv));
        chk({tg, " R8 cs line"}, 32'(cs_seen), 32'(~(4'b1 << csi) & 4'hF));
        chk({tg, " R7 mosi word"}, 32'(mosi_cap & mask), 32'(d & mask));
        rd(6, v);
        chk({tg, " R7 rx word"}, 32'(v), 32'(sw & mask));
        rd(5, v);
        chk({tg, " R10 done and idle"}, 32'(v[2] | (v[0] << 1)), 32'h2);
    endtask

    initial begin
        logic [25:0] v;
        time p0;
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a, v);
            chk("R1 format reset", 32'(v), 0);
        end
        rd(5, v);
        chk("R1 status reset", 32'(v), 0);
        chk("R1 idle lines", 32'({sclk, cs_n}), 32'h0F);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset release", 32'({sclk, cs_n}), 32'h0F);

        // R2 field storage
        wr(1, 26'h3FFFFFF);
        rd(1, v);
        chk("R2 field mask", 32'(v), 32'h0000FF1F);

        wr(0, fmtv(2, 8));
        wr(1, fmtv(4, 16));
        wr(2, fmtv(7, 5));
        wr(3, fmtv(12, 12));
        rd(3, v);
        chk("R2 readback", 32'(v), 32'h0C0C);

        // R4 each format set with its own chip select
        start_xfer(0, 0, 16'h00A5, 16'h003C, 8);
        wait_check(0, 16'h00A5, 16'h003C, 3, 8, "fmt0 R4");
        start_xfer(1, 1, 16'hC3E1, 16'h5AF0, 16);
        wait_check(1, 16'hC3E1, 16'h5AF0, 5, 16, "fmt1 R4");
        start_xfer(2, 2, 16'h0013, 16'h000A, 5);
        wait_check(2, 16'h0013, 16'h000A, 8, 5, "fmt2 R4");
        start_xfer(3, 3, 16'h0B6D, 16'h0972, 12);
        wait_check(3, 16'h0B6D, 16'h0972, 13, 12, "fmt3 R4");

        // R4 select field alone changes the frequency
        wr(3, fmtv(12, 8));
        start_xfer(0, 2, 16'h0055, 16'h00AA, 8);
        wait_check(2, 16'h0055, 16'h00AA, 3, 8, "sel0 R4");
        p0 = pmax;
        start_xfer(3, 2, 16'h0055, 16'h00AA, 8);
        wait_check(2, 16'h0055, 16'h00AA, 13, 8, "sel3 R4");
        checks++;
        if (p0 == pmax) begin
            errors++;
            $display("FAIL R4 select-only period act=%0d exp!=%0d", pmax / 4, p0 / 4);
        end

        // R10 done cleared at start, busy visible
        start_xfer(0, 1, 16'h0081, 16'h007E, 8);
        rd(5, v);
        chk("R10 done cleared busy set", 32'(v[2:0]), 32'h4);
        wait_check(1, 16'h0081, 16'h007E, 3, 8, "R10 run");

        // R9 writes during a transfer are ignored
        start_xfer(1, 0, 16'h9C3A, 16'h6E17, 16);
        repeat (20) @(negedge clk);
        wr(1, fmtv(9, 12));
        wr(4, 26'h3020FFF);
        wait_check(0, 16'h9C3A, 16'h6E17, 5, 16, "R9 latch");
        repeat (30) @(negedge clk);
        chk("R9 no late start", 32'(cs_all), 1);
        wr(1, fmtv(4, 16));

        // R5 prescale sweep on set 2
        for (int p = 0; p <= 10; p++) begin
            wr(2, fmtv(p, 4));
            start_xfer(2, 3, 16'(p + 5), 16'(15 - p), 4);
            wait_check(3, 16'(p + 5), 16'(15 - p), (p < 2) ? 3 : p + 1, 4, "R5 sweep");
            rd(5, v);
            chk("R5 illegal flag", 32'(v[1]), 32'(p < 2));
            wr(5, 26'h2);
            rd(5, v);
            chk("R5 illegal cleared", 32'(v[1]), 0);
        end

        // R6 length sweep on set 3
        for (int l = 0; l <= 17; l++) begin
            int el;
            el = (l == 0 || l > 16) ? 16 : l;
            wr(3, fmtv(2, l));
            start_xfer(3, 1, 16'hB3C5 ^ 16'(l), 16'h4D2E + 16'(l), el);
            wait_check(1, 16'hB3C5 ^ 16'(l), 16'h4D2E + 16'(l), 3, el, "R6 sweep");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule